// File: doc/BRIEF.md
# Event Counter Slice with Threshold Qualification

This block is one slice of a performance-monitoring unit. Every cycle it receives a small count (0 to 7 by default) of events that occurred in that cycle, together with the privilege ring the core is running in. A control register decides how that count is qualified before it reaches a 40-bit accumulator. The raw count can be summed. It can be reduced to a single "condition held" bit by a threshold compare, which may be inverted. It can also be reduced further to rising transitions of that bit. In every case it is gated by per-ring enables and a global enable.

Sampling works by preloading the accumulator so that it wraps after a chosen number of increments. On a wrap the accumulator reloads from a software-written reload register, with the excess of that cycle carried in. At the same time it sets a sticky overflow flag, pulses a sample request, and, when enabled, holds an interrupt request. The total event count is therefore the number of samples multiplied by the interval. A parameter gives the slice its index within the unit, and only index 0 accepts the request for precise sampling. Software reaches every register through a flat write strobe, a 3-bit address and a combinational read port.

Top module: `evt_ctr_slice`

## Requirements
- R1: With the threshold field (control bits 31:24) equal to 0, the global enable (control bit 22) set and the current ring enabled, the accumulator adds the per-cycle event count in every cycle. The user enable (control bit 16) covers ring 3 and the kernel enable (control bit 17) covers ring 0.
- R2: With a nonzero threshold, the accumulator adds exactly 1 in each qualifying cycle whose event count is greater than or equal to the threshold, and 0 otherwise.
- R3: The invert bit (control bit 23) turns the threshold test into "count less than threshold". With threshold 1 and invert set, cycles with zero events are counted.
- R4: The edge bit (control bit 18), with a nonzero threshold, adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle.
- R5: The edge history is cleared in every cycle the global enable is 0, so a condition that holds across a disable and re-enable counts again.
- R6: Counting happens only while the ring of that cycle has its enable bit set. Rings 1 and 2 never count.
- R7: While the global enable is 0, the accumulator keeps its value unless software writes it.
- R8: When an increment carries out of bit 39, the accumulator becomes the reload value (address 3 holds bits 31:0, address 4 bits 7:0 hold bits 39:32) plus the wrapped remainder. Status bit 0 (address 5) becomes 1, and sample_req is high for exactly the following cycle.
- R9: irq is high while status bit 0 and the interrupt enable (control bit 20) are both 1. Writing 1 to status bit 0 clears it.
- R10: A software write to the accumulator low half (address 1) or high half (address 2, bits 7:0) replaces that half and suppresses the increment of that cycle, including any overflow.
- R11: On index 0, the precise bit (control bit 19) is stored, and precise_sample pulses together with sample_req. On any other index the bit reads back as 0, and a write that sets it sets status bit 1, which is cleared by writing 1.
- R12: With threshold 0, the invert and edge bits have no effect.
- R13: After reset, all registers read 0 and irq, sample_req and precise_sample are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_count | input | EVT_W | Events seen this cycle |
| priv_ring | input | 2 | Current privilege ring (0 kernel, 3 user) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1/2 counter, 3/4 reload, 5 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Overflow interrupt request |
| sample_req | output | 1 | One-cycle pulse after an overflow |
| precise_sample | output | 1 | One-cycle pulse after an overflow while precise mode is set |

## Verification
The hardest behaviour to reach from the ports is the 40-bit wrap. Counting up to it would take about 10^12 increments, so the bench writes both counter halves to a few counts below the top and writes the reload value separately. It then steps small event counts across the boundary, so that the remainder carried into the reload value is nonzero. Clearing the edge history is the second awkward case. The event input is held high while the control word is rewritten disabled and then enabled again, so only a cleared history lets the second rising edge count. A second instance with index 1 shares the same stimulus to show that it refuses the precise request.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] ADDR_CTL    = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_CNT_LO = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_CNT_HI = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_RLD_LO = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_RLD_HI = 3'd4;
  localparam logic [REG_AW-1:0] ADDR_STS    = 3'd5;

  localparam int PRECISE_BIT = 19;

  // Control word, MSB first
  typedef struct packed {
    logic [7:0] thresh;   // 31:24
    logic       invert;   // 23
    logic       enable;   // 22
    logic       rsvd;     // 21
    logic       irq_en;   // 20
    logic       precise;  // 19
    logic       edge_md;  // 18
    logic       kern_en;  // 17
    logic       user_en;  // 16
    logic [7:0] umask;    // 15:8
    logic [7:0] evsel;    // 7:0
  } ctl_t;

  // Threshold compare on a zero-extended count
  function automatic logic thr_pass(input logic [7:0] cnt8, input logic [7:0] thr,
                                    input logic inv);
    return inv ? (cnt8 < thr) : (cnt8 >= thr);
  endfunction

  // Ring 3 uses the user bit, ring 0 the kernel bit, others never count
  function automatic logic ring_ok(input logic [1:0] ring, input logic usr,
                                   input logic krn);
    return ((ring == 2'd3) && usr) || ((ring == 2'd0) && krn);
  endfunction

endpackage

// File: rtl/evt_qualifier.sv
module evt_qualifier
  import evt_ctr_pkg::*;
#(
  parameter int EVT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_count,
  input  logic [1:0]       priv_ring,
  input  logic             en,
  input  logic             usr,
  input  logic             krn,
  input  logic             edge_md,
  input  logic             inv,
  input  logic [7:0]       thr,
  output logic [EVT_W-1:0] inc_amt
);

  localparam logic [EVT_W-1:0] ONE = EVT_W'(1);

  logic       live;
  logic       cond;
  logic       qual;
  logic       hist_q;
  logic       rise;
  logic [7:0] evt8;

  assign evt8 = 8'(evt_count);
  assign live = en && ring_ok(priv_ring, usr, krn);
  assign cond = thr_pass(evt8, thr, inv);
  assign qual = live && cond;
  assign rise = qual && !hist_q;

  always_comb begin
    if (thr == 8'd0)  inc_amt = live ? evt_count : '0;
    else if (edge_md) inc_amt = rise ? ONE : '0;
    else              inc_amt = qual ? ONE : '0;
  end

  // History follows the qualified condition, cleared while disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hist_q <= 1'b0;
    else if (!en) hist_q <= 1'b0;
    else          hist_q <= qual;
  end

endmodule

// File: rtl/evt_accum.sv
module evt_accum #(
  parameter int CNT_W = 40,
  parameter int EVT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] inc_amt,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt
);

  localparam int HI_W = CNT_W - 32;

  function automatic logic [CNT_W:0] widen_add(input logic [CNT_W-1:0] a,
                                               input logic [EVT_W-1:0] b);
    return {1'b0, a} + (CNT_W+1)'(b);
  endfunction

  function automatic logic [CNT_W-1:0] wrap_next(input logic [CNT_W:0] s,
                                                 input logic [CNT_W-1:0] rl);
    return s[CNT_W] ? (rl + s[CNT_W-1:0]) : s[CNT_W-1:0];
  endfunction

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nxt;
  logic             sw_wr;

  assign sum     = widen_add(cnt_q, inc_amt);
  assign nxt     = wrap_next(sum, reload);
  assign sw_wr   = wr_lo || wr_hi;
  assign ovf_evt = sum[CNT_W] && !sw_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sw_wr) begin
      if (wr_lo) cnt_q[31:0]       <= wdata;
      if (wr_hi) cnt_q[CNT_W-1:32] <= wdata[HI_W-1:0];
    end else if (inc_amt != '0) begin
      cnt_q <= nxt;
    end
  end

endmodule

// File: rtl/evt_ctr_regs.sv
module evt_ctr_regs
  import evt_ctr_pkg::*;
#(
  parameter int CNT_W = 40,
  parameter int INDEX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              ovf_evt,
  output ctl_t              ctl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              ovf_sticky,
  output logic [31:0]       reg_rdata
);

  localparam int HI_W = CNT_W - 32;

  logic wr_ctl, wr_rlo, wr_rhi, wr_sts;
  logic precise_allowed;
  logic rej_sticky;
  ctl_t ctl_nxt;

  generate
    if (INDEX == 0) begin : g_precise_ok
      assign precise_allowed = 1'b1;
    end else begin : g_precise_no
      assign precise_allowed = 1'b0;
    end
  endgenerate

  assign wr_ctl = reg_wr && (reg_addr == ADDR_CTL);
  assign wr_lo  = reg_wr && (reg_addr == ADDR_CNT_LO);
  assign wr_hi  = reg_wr && (reg_addr == ADDR_CNT_HI);
  assign wr_rlo = reg_wr && (reg_addr == ADDR_RLD_LO);
  assign wr_rhi = reg_wr && (reg_addr == ADDR_RLD_HI);
  assign wr_sts = reg_wr && (reg_addr == ADDR_STS);

  always_comb begin
    ctl_nxt         = ctl_t'(reg_wdata);
    ctl_nxt.rsvd    = 1'b0;
    ctl_nxt.precise = reg_wdata[PRECISE_BIT] && precise_allowed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_nxt;
      if (wr_rlo) reload_q[31:0]       <= reg_wdata;
      if (wr_rhi) reload_q[CNT_W-1:32] <= reg_wdata[HI_W-1:0];
    end
  end

  // Sticky flags: a new set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_sticky <= 1'b0;
      rej_sticky <= 1'b0;
    end else begin
      if (ovf_evt)                     ovf_sticky <= 1'b1;
      else if (wr_sts && reg_wdata[0]) ovf_sticky <= 1'b0;
      if (wr_ctl && reg_wdata[PRECISE_BIT] && !precise_allowed) rej_sticky <= 1'b1;
      else if (wr_sts && reg_wdata[1])                          rej_sticky <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTL:    reg_rdata = ctl_q;
      ADDR_CNT_LO: reg_rdata = cnt_q[31:0];
      ADDR_CNT_HI: reg_rdata = 32'(cnt_q[CNT_W-1:32]);
      ADDR_RLD_LO: reg_rdata = reload_q[31:0];
      ADDR_RLD_HI: reg_rdata = 32'(reload_q[CNT_W-1:32]);
      ADDR_STS:    reg_rdata = {30'd0, rej_sticky, ovf_sticky};
      default:     reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice
  import evt_ctr_pkg::*;
#(
  parameter int CNT_W = 40,
  parameter int EVT_W = 3,
  parameter int INDEX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_count,
  input  logic [1:0]        priv_ring,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              sample_req,
  output logic              precise_sample
);

  ctl_t             ctl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EVT_W-1:0] inc_amt;
  logic             wr_lo, wr_hi;
  logic             ovf_evt;
  logic             ovf_sticky;

  // Named wires for the checker
  logic       chk_en;
  logic       chk_edge;
  logic       chk_irq_en;
  logic [7:0] chk_thr;
  logic       cnt_wr;

  assign chk_en     = ctl_q.enable;
  assign chk_edge   = ctl_q.edge_md;
  assign chk_irq_en = ctl_q.irq_en;
  assign chk_thr    = ctl_q.thresh;
  assign cnt_wr     = wr_lo || wr_hi;

  evt_ctr_regs #(.CNT_W(CNT_W), .INDEX(INDEX)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .cnt_q      (cnt_q),
    .ovf_evt    (ovf_evt),
    .ctl_q      (ctl_q),
    .reload_q   (reload_q),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .ovf_sticky (ovf_sticky),
    .reg_rdata  (reg_rdata)
  );

  evt_qualifier #(.EVT_W(EVT_W)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_count (evt_count),
    .priv_ring (priv_ring),
    .en        (ctl_q.enable),
    .usr       (ctl_q.user_en),
    .krn       (ctl_q.kern_en),
    .edge_md   (ctl_q.edge_md),
    .inv       (ctl_q.invert),
    .thr       (ctl_q.thresh),
    .inc_amt   (inc_amt)
  );

  evt_accum #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_amt (inc_amt),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wdata   (reg_wdata),
    .reload  (reload_q),
    .cnt_q   (cnt_q),
    .ovf_evt (ovf_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_req     <= 1'b0;
      precise_sample <= 1'b0;
    end else begin
      sample_req     <= ovf_evt;
      precise_sample <= ovf_evt && ctl_q.precise;
    end
  end

  assign irq = ovf_sticky && ctl_q.irq_en;

endmodule

// File: rtl/evt_ctr_chk.sv
module evt_ctr_chk #(
  parameter int CNT_W = 40,
  parameter int EVT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       priv_ring,
  input logic [EVT_W-1:0] inc_amt,
  input logic             chk_en,
  input logic             chk_edge,
  input logic [7:0]       chk_thr,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             sample_req,
  input logic             precise_sample,
  input logic             ovf_sticky
);

  logic edge_on;
  assign edge_on = chk_en && chk_edge && (chk_thr != 8'd0);

  // R2: threshold mode steps by at most one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_thr != 8'd0) |-> (inc_amt <= EVT_W'(1)));

  // R4: edge mode never increments in two consecutive cycles
  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_on && inc_amt != '0) |=> !(edge_on && inc_amt != '0));

  // R6: rings 1 and 2 never count
  a_r6_ring_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_ring == 2'd1 || priv_ring == 2'd2) |-> (inc_amt == '0));

  // R7: disabled counter holds unless written
  a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_en && !cnt_wr) |=> $stable(cnt_q));

  // R8: a sample pulse always comes with the sticky flag
  a_r8_sample_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |-> ovf_sticky);

  // R10: a software counter write suppresses overflow
  a_r10_write_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !sample_req);

  // R11: precise pulse is a subset of the sample pulse
  a_r11_precise_subset: assert property (@(posedge clk) disable iff (!rst_n)
    precise_sample |-> sample_req);

endmodule

bind evt_ctr_slice evt_ctr_chk #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .priv_ring      (priv_ring),
  .inc_amt        (inc_amt),
  .chk_en         (chk_en),
  .chk_edge       (chk_edge),
  .chk_thr        (chk_thr),
  .cnt_wr         (cnt_wr),
  .cnt_q          (cnt_q),
  .sample_req     (sample_req),
  .precise_sample (precise_sample),
  .ovf_sticky     (ovf_sticky)
);

// File: tb/evt_ctr_slice_tb.sv
module evt_ctr_slice_tb;

  localparam logic [31:0] C_USR = 32'h1 << 16;
  localparam logic [31:0] C_KRN = 32'h1 << 17;
  localparam logic [31:0] C_EDG = 32'h1 << 18;
  localparam logic [31:0] C_PRC = 32'h1 << 19;
  localparam logic [31:0] C_IRQ = 32'h1 << 20;
  localparam logic [31:0] C_EN  = 32'h1 << 22;
  localparam logic [31:0] C_INV = 32'h1 << 23;
  localparam logic [63:0] TOP   = 64'h100_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  evt_in = '0;
  logic [1:0]  ring = 2'd3;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata1;
  logic        irq, sample_req, precise_sample;
  logic        irq1, sample1, precise1;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  evt_ctr_slice u_dut (
    .clk(clk), .rst_n(rst_n), .evt_count(evt_in), .priv_ring(ring),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .irq(irq), .sample_req(sample_req),
    .precise_sample(precise_sample)
  );

  evt_ctr_slice #(.INDEX(1)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .evt_count(evt_in), .priv_ring(ring),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata1), .irq(irq1), .sample_req(sample1),
    .precise_sample(precise1)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = rdata;
  endtask

  task automatic rd1(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = rdata1;
  endtask

  task automatic rd_cnt(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(3'd1, lo); rd(3'd2, hi);
    v = {hi, lo};
  endtask

  task automatic run(input int e, input int n);
    for (int i = 0; i < n; i++) begin
      evt_in = 3'(e);
      @(negedge clk);
    end
    evt_in = '0;
  endtask

  task automatic prep();
    wr(3'd0, 32'd0); wr(3'd1, 32'd0); wr(3'd2, 32'd0); wr(3'd5, 32'd3);
    ring = 2'd3;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R13 register reset", 64'(d), 64'd0);
    end
    chk("R13 outputs reset", {61'd0, irq, sample_req, precise_sample}, 64'd0);
  endtask

  task automatic t_plain();
    logic [63:0] v;
    prep();
    wr(3'd0, C_EN | C_USR | C_KRN);
    run(5, 1); run(3, 1); run(7, 1); run(0, 1); run(2, 1);
    wr(3'd0, 32'd0);
    rd_cnt(v); chk("R1 plain sum", v, 64'd17);
  endtask

  task automatic t_thresh();
    logic [63:0] v;
    prep();
    wr(3'd0, C_EN | C_USR | C_KRN | (32'd3 << 24));
    run(1, 1); run(3, 1); run(5, 1); run(2, 1); run(7, 1); run(3, 1);
    wr(3'd0, 32'd0);
    rd_cnt(v); chk("R2 threshold 3", v, 64'd4);
  endtask

  task automatic t_invert();
    logic [63:0] v;
    prep();
    wr(3'd0, C_EN | C_USR | C_KRN | C_INV | (32'd1 << 24));
    run(0, 1); run(2, 1); run(0, 2); run(4, 1);
    wr(3'd0, 32'd0);   // this cycle has zero events and still counts
    rd_cnt(v); chk("R3 invert zero cycles", v, 64'd4);
  endtask

  task automatic t_edge();
    logic [63:0] v;
    prep();
    wr(3'd0, C_EN | C_USR | C_KRN | C_EDG | (32'd2 << 24));
    run(0, 1); run(3, 3); run(0, 1); run(2, 1); run(0, 1); run(5, 2);
    wr(3'd0, 32'd0);
    rd_cnt(v); chk("R4 edge rises", v, 64'd3);
  endtask

  task automatic t_edge_hist();
    logic [63:0] v;
    prep();
    evt_in = 3'd4;
    wr(3'd0, C_EN | C_USR | C_KRN | C_EDG | (32'd1 << 24));
    repeat (3) @(negedge clk);
    wr(3'd0, C_USR | C_KRN | C_EDG | (32'd1 << 24));
    wr(3'd0, C_EN | C_USR | C_KRN | C_EDG | (32'd1 << 24));
    repeat (2) @(negedge clk);
    evt_in = '0;
    wr(3'd0, 32'd0);
    rd_cnt(v); chk("R5 history cleared by disable", v, 64'd2);
  endtask

  task automatic t_priv();
    logic [63:0] v;
    prep();
    wr(3'd0, C_EN | C_USR);
    ring = 2'd0; run(5, 3);
    ring = 2'd3; run(2, 2);
    ring = 2'd1; run(7, 1);
    ring = 2'd2; run(7, 1);
    ring = 2'd3; wr(3'd0, 32'd0);
    rd_cnt(v); chk("R6 user only", v, 64'd4);
    prep();
    wr(3'd0, C_EN | C_KRN);
    ring = 2'd0; run(3, 2);
    ring = 2'd3; run(3, 2);
    ring = 2'd0; wr(3'd0, 32'd0);
    rd_cnt(v); chk("R6 kernel only", v, 64'd6);
  endtask

  task automatic t_disabled();
    logic [63:0] v;
    prep();
    wr(3'd0, C_USR | C_KRN);
    run(7, 5);
    rd_cnt(v); chk("R7 disabled holds", v, 64'd0);
  endtask

  task automatic t_overflow();
    logic [63:0] v;
    logic [31:0] d;
    prep();
    wr(3'd3, 32'hFFFF_FFF6); wr(3'd4, 32'hFF);       // reload = TOP-10
    wr(3'd1, 32'hFFFF_FFFB); wr(3'd2, 32'hFF);       // counter = TOP-5
    wr(3'd0, C_EN | C_USR | C_KRN | C_IRQ);
    run(1, 4);
    rd_cnt(v); chk("R8 just below top", v, TOP - 1);
    chk("R8 no early sample", 64'(sample_req), 64'd0);
    evt_in = 3'd3;
    @(negedge clk);
    evt_in = '0;
    chk("R8 sample pulse", 64'(sample_req), 64'd1);
    chk("R11 no precise when bit clear", 64'(precise_sample), 64'd0);
    @(negedge clk);
    chk("R8 sample pulse one cycle", 64'(sample_req), 64'd0);
    wr(3'd0, C_IRQ);
    rd_cnt(v); chk("R8 reload plus remainder", v, TOP - 8);
    rd(3'd5, d); chk("R8 sticky status", 64'(d), 64'd1);
    chk("R9 irq raised", 64'(irq), 64'd1);
    wr(3'd5, 32'd1);
    rd(3'd5, d); chk("R9 status cleared", 64'(d), 64'd0);
    chk("R9 irq dropped", 64'(irq), 64'd0);
    wr(3'd0, C_EN | C_USR | C_KRN);
    run(1, 8);
    rd_cnt(v); chk("R8 wrap lands on reload", v, TOP - 10);
    run(1, 10);
    wr(3'd0, 32'd0);
    rd_cnt(v); chk("R8 full interval", v, TOP - 10);
  endtask

  task automatic t_no_irq();
    logic [63:0] v;
    logic [31:0] d;
    prep();
    wr(3'd3, 32'h1234); wr(3'd4, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF); wr(3'd2, 32'hFF);
    wr(3'd0, C_EN | C_USR | C_KRN);
    run(1, 1);
    wr(3'd0, 32'd0);
    rd_cnt(v); chk("R8 reload exact", v, 64'h1234);
    rd(3'd5, d); chk("R9 status set without irq enable", 64'(d), 64'd1);
    chk("R9 irq masked", 64'(irq), 64'd0);
  endtask

  task automatic t_wr_prio();
    logic [63:0] v;
    logic [31:0] d;
    prep();
    wr(3'd0, C_EN | C_USR | C_KRN);
    evt_in = 3'd7;
    wr(3'd1, 32'd100);
    rd_cnt(v); chk("R10 write beats increment", v, 64'd100);
    evt_in = '0;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF); wr(3'd2, 32'hFF); wr(3'd5, 32'd3);
    wr(3'd0, C_EN | C_USR | C_KRN);
    evt_in = 3'd7;
    wr(3'd1, 32'd5);
    chk("R10 no sample on write", 64'(sample_req), 64'd0);
    evt_in = '0;
    wr(3'd0, 32'd0);
    rd_cnt(v); chk("R10 written value kept", v, 64'hFF_0000_0005);
    rd(3'd5, d); chk("R10 no overflow flag", 64'(d), 64'd0);
  endtask

  task automatic t_precise();
    logic [31:0] d;
    prep();
    wr(3'd5, 32'd3);
    wr(3'd0, C_PRC);
    rd(3'd0, d);  chk("R11 index0 keeps bit", 64'(d[19]), 64'd1);
    rd1(3'd0, d); chk("R11 index1 drops bit", 64'(d[19]), 64'd0);
    rd1(3'd5, d); chk("R11 index1 reject flag", 64'(d), 64'd2);
    rd(3'd5, d);  chk("R11 index0 no reject", 64'(d), 64'd0);
    wr(3'd5, 32'd2);
    rd1(3'd5, d); chk("R11 reject flag cleared", 64'(d), 64'd0);
    wr(3'd1, 32'hFFFF_FFFF); wr(3'd2, 32'hFF);
    wr(3'd0, C_EN | C_USR | C_KRN | C_PRC);
    evt_in = 3'd1;
    @(negedge clk);
    evt_in = '0;
    chk("R11 precise pulse", 64'(precise_sample), 64'd1);
    chk("R11 index1 no precise pulse", 64'(precise1), 64'd0);
    wr(3'd0, 32'd0);
  endtask

  task automatic t_thr0();
    logic [63:0] v;
    prep();
    wr(3'd0, C_EN | C_USR | C_KRN | C_INV | C_EDG);
    run(3, 3);
    wr(3'd0, 32'd0);
    rd_cnt(v); chk("R12 invert and edge ignored", v, 64'd9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_thresh();
    t_invert();
    t_edge();
    t_edge_hist();
    t_priv();
    t_disabled();
    t_overflow();
    t_no_irq();
    t_wr_prio();
    t_precise();
    t_thr0();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule